// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the target side of a four-wire serial link from a host controller. It takes the serial clock, the data line and an active-low select from the host. It brings all three into the local system clock domain and rebuilds one 16-bit word per select period. The upper four bits of the word name an operation and the lower twelve bits carry its argument.

A configuration-write operation places the low eight argument bits into a mode register that drives the rest of the chip. The same edge raises a single-cycle strobe. A no-operation code is accepted and does nothing. Any other code raises a sticky error output, and the mode register keeps its value. A select period that frames any bit count other than sixteen is dropped without effect.

Top module: `cmd_word_rx`

## Requirements
- R1: After reset, `mode_o` is 0x00 and `mode_stb_o` and `cmd_err_o` are low.
- R2: A word is formed from the data line sampled on the rising edges of the serial clock while the select is low. The first bit sampled is bit 15 and the last is bit 0, so the first bit sent is the most significant.
- R3: A complete word with bits 15..12 equal to 4'h1 loads bits 7..0 into `mode_o`. Bits 11..8 have no effect.
- R4: Each accepted configuration-write word raises `mode_stb_o` for exactly one system clock, on the same edge that `mode_o` takes the new value.
- R5: When the select rises after fewer than 16 clock edges, including zero, the partial word is discarded. `mode_o`, `cmd_err_o` and `mode_stb_o` do not change.
- R6: When the select rises after more than 16 clock edges, the word is discarded with the same lack of effect.
- R7: A complete word with bits 15..12 equal to 4'h0 is a no-operation. It changes no output and raises no strobe.
- R8: A complete word with bits 15..12 in the range 4'h2 to 4'hF sets `cmd_err_o`. `mode_o` is left unchanged and no strobe is raised.
- R9: Once set, `cmd_err_o` stays high until reset. Later valid words are still carried out while it is high.
- R10: Serial clock edges that arrive while the select is high do not shift data or count bits. The next framed word is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| mosi_i | input | 1 | Serial data from the host, MSB first |
| cs_n_i | input | 1 | Active-low select; frames one word |
| mode_o | output | 8 | Mode register value |
| mode_stb_o | output | 1 | One-cycle pulse when the mode register is written |
| cmd_err_o | output | 1 | Sticky flag for an unrecognised operation code |

## Verification
A corrupted shift register or bit counter shows at the ports four system clocks after the select rises. At that point the mode register holds the wrong value, a strobe is missing or extra, or the error flag is set when it should not be. Each stimulus word is chosen so that a bit-order reversal, a wrong field split or an off-by-one in the length test changes the visible mode value or the error flag. A wrong decode is caught on the first word of the affected code. A lost sticky state is caught by the valid word that follows an error.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    localparam int WORD_W = 16;
    localparam int CMD_W  = 4;
    localparam int DATA_W = WORD_W - CMD_W;
    localparam int MODE_W = 8;

    typedef enum logic [CMD_W-1:0] {
        OP_NOP    = 4'h0,
        OP_SETCFG = 4'h1
    } op_e;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [DATA_W-1:0] arg;
    } cmd_word_t;

endpackage

// File: rtl/cwr_sync.sv
module cwr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cwr_deser.sv
module cwr_deser
    import cwr_pkg::*;
#(
    parameter int BITS = WORD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            mosi_s,
    input  logic            cs_n_s,
    output logic            word_vld_o,
    output logic [BITS-1:0] word_o
);

    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BITS + 1);

    typedef struct packed {
        logic             sclk_prev;
        logic             cs_prev;
        logic [BITS-1:0]  shreg;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [BITS-1:0]  word;
    } deser_t;

    deser_t st_d, st_q;
    logic   sclk_rise;
    logic   cs_rise;

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.cs_prev   = cs_n_s;
        sclk_rise      = sclk_s & ~st_q.sclk_prev;
        cs_rise        = cs_n_s & ~st_q.cs_prev;

        if (cs_n_s) begin
            // select idle: close the frame, accept only an exact-length word
            if (cs_rise && (st_q.cnt == CNT_FULL)) begin
                st_d.vld  = 1'b1;
                st_d.word = st_q.shreg;
            end
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.shreg = {st_q.shreg[BITS-2:0], mosi_s};
            if (st_q.cnt != CNT_OVER) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.cs_prev   <= 1'b1;
            st_q.shreg     <= '0;
            st_q.cnt       <= '0;
            st_q.vld       <= 1'b0;
            st_q.word      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_vld_o = st_q.vld;
    assign word_o     = st_q.word;

endmodule

// File: rtl/cwr_decode.sv
module cwr_decode
    import cwr_pkg::*;
#(
    parameter int MODE_BITS = MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 word_vld_i,
    input  cmd_word_t            word_i,
    output logic [MODE_BITS-1:0] mode_o,
    output logic                 mode_stb_o,
    output logic                 err_o
);

    typedef struct packed {
        logic [MODE_BITS-1:0] mode;
        logic                 stb;
        logic                 err;
    } dec_t;

    dec_t st_d, st_q;
    logic unused_arg_hi;

    assign unused_arg_hi = ^word_i.arg[DATA_W-1:MODE_BITS];

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (word_vld_i) begin
            case (word_i.op)
                OP_NOP: begin
                end
                OP_SETCFG: begin
                    st_d.mode = word_i.arg[MODE_BITS-1:0];
                    st_d.stb  = 1'b1;
                end
                default: begin
                    st_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign mode_stb_o = st_q.stb;
    assign err_o      = st_q.err;

endmodule

// File: rtl/cmd_word_rx.sv
module cmd_word_rx
    import cwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MODE_BITS   = MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 mosi_i,
    input  logic                 cs_n_i,
    output logic [MODE_BITS-1:0] mode_o,
    output logic                 mode_stb_o,
    output logic                 cmd_err_o
);

    // bit order of the synchronised bundle
    localparam int IDX_SCLK = 0;
    localparam int IDX_MOSI = 1;
    localparam int IDX_CSN  = 2;
    localparam int N_SYNC   = 3;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_in;
    logic              word_vld;
    logic [WORD_W-1:0] word_raw;
    cmd_word_t         word;

    assign raw_in[IDX_SCLK] = sclk_i;
    assign raw_in[IDX_MOSI] = mosi_i;
    assign raw_in[IDX_CSN]  = cs_n_i;

    cwr_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (N_SYNC'(1) << IDX_CSN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    cwr_deser #(
        .BITS (WORD_W)
    ) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sync_in[IDX_SCLK]),
        .mosi_s     (sync_in[IDX_MOSI]),
        .cs_n_s     (sync_in[IDX_CSN]),
        .word_vld_o (word_vld),
        .word_o     (word_raw)
    );

    assign word = cmd_word_t'(word_raw);

    cwr_decode #(
        .MODE_BITS (MODE_BITS)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld_i (word_vld),
        .word_i     (word),
        .mode_o     (mode_o),
        .mode_stb_o (mode_stb_o),
        .err_o      (cmd_err_o)
    );

endmodule

// File: rtl/cwr_chk.sv
module cwr_chk #(
    parameter int MODE_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MODE_BITS-1:0] mode,
    input logic                 mode_stb,
    input logic                 err,
    input logic                 word_vld
);

    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_stb |=> !mode_stb); // R4

    AST_MODE_ONLY_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> mode_stb); // R4

    AST_STB_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_stb |-> $past(word_vld)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!mode_stb && $stable(mode))); // R8

    AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R10

endmodule

bind cmd_word_rx cwr_chk #(.MODE_BITS(MODE_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_o),
    .mode_stb (mode_stb_o),
    .err      (cmd_err_o),
    .word_vld (word_vld)
);

// File: tb/cmd_word_rx_tb.sv
`timescale 1ns/1ps
module cmd_word_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] mode;
    logic       mode_stb;
    logic       cmd_err;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmd_word_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .mosi_i     (mosi),
        .cs_n_i     (cs_n),
        .mode_o     (mode),
        .mode_stb_o (mode_stb),
        .cmd_err_o  (cmd_err)
    );

    always @(posedge clk) begin
        if (rst_n && mode_stb) stb_cnt <= stb_cnt + 1;
    end

    // {word[15:0], nbits[4:0], exp_mode[7:0], exp_err, exp_strobes}
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {16'h10A5, 5'd16, 8'hA5, 1'b0, 1'b1},  // R2 R3 R4
        {16'h1F3C, 5'd16, 8'h3C, 1'b0, 1'b1},  // R3 high arg bits ignored
        {16'h1001, 5'd16, 8'h01, 1'b0, 1'b1},  // R2 bit order
        {16'h10FF, 5'd15, 8'h01, 1'b0, 1'b0},  // R5 short
        {16'h1055, 5'd17, 8'h01, 1'b0, 1'b0},  // R6 long
        {16'h00EE, 5'd16, 8'h01, 1'b0, 1'b0},  // R7 no-op
        {16'h10C3, 5'd16, 8'hC3, 1'b0, 1'b1},  // R2 R4
        {16'h0000, 5'd0,  8'hC3, 1'b0, 1'b0},  // R5 empty frame
        {16'h7012, 5'd16, 8'hC3, 1'b1, 1'b0}   // R8 unknown code
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int nbits);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? w[15-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        do_reset();
        // R1 reset state
        check(mode == 8'h00, "R1 mode", mode, 0);
        check(cmd_err == 1'b0, "R1 err", cmd_err, 0);
        check(mode_stb == 1'b0 && stb_cnt == 0, "R1 strobe", stb_cnt, 0);

        for (int v = 0; v < NV; v++) begin
            logic [30:0] e;
            e = VEC[v];
            s0 = stb_cnt;
            send(e[30:15], int'(e[14:10]));
            check(mode == e[9:2], $sformatf("R2/R3 vec%0d mode", v), mode, e[9:2]);
            check(cmd_err == e[1], $sformatf("R7/R8 vec%0d err", v), cmd_err, e[1]);
            check((stb_cnt - s0) == int'(e[0]), $sformatf("R4/R5/R6 vec%0d strobes", v),
                  stb_cnt - s0, e[0]);
        end

        // R9: error stays set and valid words still execute
        s0 = stb_cnt;
        send(16'h1066, 16);
        check(mode == 8'h66, "R9 mode after error", mode, 8'h66);
        check(cmd_err == 1'b1, "R9 err sticky", cmd_err, 1);
        check(stb_cnt - s0 == 1, "R9 strobe", stb_cnt - s0, 1);
        wait_clk(20);
        check(cmd_err == 1'b1, "R9 err held", cmd_err, 1);

        // R1: reset clears state
        do_reset();
        check(mode == 8'h00, "R1 mode after reset", mode, 0);
        check(cmd_err == 1'b0, "R1 err after reset", cmd_err, 0);

        // R10: serial clock edges with select high are ignored
        s0 = stb_cnt;
        mosi = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(10);
        check(mode == 8'h00 && stb_cnt == s0, "R10 no effect idle", mode, 0);
        send(16'h105A, 16);
        check(mode == 8'h5A, "R10 next word", mode, 8'h5A);
        check(cmd_err == 1'b0, "R10 err", cmd_err, 0);

        // R6 boundary: 31 edges, R5 boundary: 1 edge
        send(16'h1011, 31);
        check(mode == 8'h5A, "R6 long frame", mode, 8'h5A);
        send(16'h1022, 1);
        check(mode == 8'h5A, "R5 one-bit frame", mode, 8'h5A);
        // R8 highest code
        s0 = stb_cnt;
        send(16'hF0AA, 16);
        check(cmd_err == 1'b1 && mode == 8'h5A, "R8 code F", {cmd_err, mode}, 9'h15A);
        check(stb_cnt == s0, "R8 no strobe", stb_cnt - s0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule